// File: doc/BRIEF.md
# Self-Recovering Triplicated Register

This block holds a `WIDTH`-bit value as three redundant copies. Each copy sits in its own redundancy domain and has its own clock input. Every domain has a private majority voter that reads all three copies. On each edge, a copy that is not being written takes its own voter's result. The state is therefore refreshed continuously, so a single corrupted copy is restored on the next edge and faults cannot pile up over time. This matters most for state-machine registers, whose next state depends on the current one.

Each domain has its own data input and its own load enable. A domain whose enable is high captures its own data. A domain whose enable is low re-captures the voted value. Each domain drives one voted output. A per-bit flag marks every bit position where the three copies do not all agree. If two copies are wrong in the same way, the voters cannot tell the fault apart from a valid value. They then pass the wrong value on and spread it to the third copy.

Top module: `tmr_refresh_reg`

## Requirements
- R1: A synchronous reset high at an edge loads `RESET_VAL` into every copy. Afterwards all three voted outputs equal `RESET_VAL` and the flag vector is zero.
- R2: Each voted output bit is 1 exactly when at least two of the three copies hold 1 at that bit (copy patterns 011, 101, 110 and 111), and 0 otherwise.
- R3: When all three enables are high with identical data, all three voted outputs show that data right after the edge.
- R4: When exactly one domain loads data while the other two are idle, the voted outputs keep their previous value. The flag vector then has ones exactly at the bits where the loaded data differs from that value.
- R5: An idle domain reloads its voted value. After an idle edge that follows a single-copy divergence, the flag vector returns to zero and the outputs are unchanged.
- R6: The three voted outputs are equal in every cycle.
- R7: When two domains load the same value while the third is idle, that value becomes the voted result after the edge, even though it is wrong for the idle copy. The next all-idle edge overwrites the third copy with it.
- R8: Flag bit i is high exactly when the three copies are not all equal at bit i.
- R9: With all enables high and three different data words, the outputs after the edge equal the bitwise majority of the three words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of domain 0 |
| clk_b | input | 1 | Clock of domain 1 |
| clk_c | input | 1 | Clock of domain 2 |
| rst | input | 1 | Synchronous reset, active high, seen by every domain |
| en_a | input | 1 | Load enable of domain 0 |
| en_b | input | 1 | Load enable of domain 1 |
| en_c | input | 1 | Load enable of domain 2 |
| d_a | input | WIDTH | Data for domain 0 |
| d_b | input | WIDTH | Data for domain 1 |
| d_c | input | WIDTH | Data for domain 2 |
| q_a | output | WIDTH | Voted value from the domain 0 voter |
| q_b | output | WIDTH | Voted value from the domain 1 voter |
| q_c | output | WIDTH | Voted value from the domain 2 voter |
| mismatch | output | WIDTH | Per-bit disagreement among the three copies |

## Verification
The temporal assertions are clocked on the domain 0 clock. They assume that the three domain clocks rise together, so that one edge of `clk_a` stands for an update of every copy. The bench meets this assumption by driving a single 125 MHz clock into all three clock pins. It also changes inputs only at the falling edge.

A divergence between copies is created through the ports alone. One or two domains load data that differs from the others, which models an upset in those copies. A behavioural model of the three copies is compared against the outputs on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned NUM_DOMAINS = 3;

   // two-of-three vote on a single bit
   function automatic logic vote_bit(input logic x, input logic y, input logic z);
      return (x & y) | (y & z) | (x & z);
   endfunction
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] copy0,
   input  logic [WIDTH-1:0] copy1,
   input  logic [WIDTH-1:0] copy2,
   output logic [WIDTH-1:0] voted
);
   import tmr_pkg::*;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign voted[i] = vote_bit(copy0[i], copy1[i], copy2[i]);
   end

   // R2: the result always agrees with at least two copies
   always_comb begin
      assert_vote_majority_R2: assert (((~(voted ^ copy0)) & (~(voted ^ copy1)) |
                                        (~(voted ^ copy1)) & (~(voted ^ copy2)) |
                                        (~(voted ^ copy0)) & (~(voted ^ copy2))) == {WIDTH{1'b1}});
   end
endmodule

// File: rtl/tmr_cell.sv
module tmr_cell #(
   parameter int unsigned    WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   input  logic [WIDTH-1:0] refresh,
   output logic [WIDTH-1:0] state
);
   always_ff @(posedge clk) begin
      if (rst)
         state <= RESET_VAL;
      else if (load)
         state <= din;
      else
         state <= refresh;
   end
endmodule

// File: rtl/tmr_refresh_reg.sv
module tmr_refresh_reg #(
   parameter int unsigned      WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = 8'hA5
) (
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             clk_c,
   input  logic             rst,
   input  logic             en_a,
   input  logic             en_b,
   input  logic             en_c,
   input  logic [WIDTH-1:0] d_a,
   input  logic [WIDTH-1:0] d_b,
   input  logic [WIDTH-1:0] d_c,
   output logic [WIDTH-1:0] q_a,
   output logic [WIDTH-1:0] q_b,
   output logic [WIDTH-1:0] q_c,
   output logic [WIDTH-1:0] mismatch
);
   import tmr_pkg::*;

   localparam int unsigned ND = NUM_DOMAINS;

   if (WIDTH < 1) begin : g_bad_width
      $error("tmr_refresh_reg: WIDTH must be at least 1");
   end

   logic [ND-1:0]    dom_clk;
   logic [ND-1:0]    dom_en;
   logic [WIDTH-1:0] dom_din  [ND];
   logic [WIDTH-1:0] dom_copy [ND];
   logic [WIDTH-1:0] dom_vote [ND];

   assign dom_clk    = {clk_c, clk_b, clk_a};
   assign dom_en     = {en_c, en_b, en_a};
   assign dom_din[0] = d_a;
   assign dom_din[1] = d_b;
   assign dom_din[2] = d_c;

   // one voter and one storage copy per domain; each voter sees all copies
   for (genvar k = 0; k < ND; k++) begin : g_dom
      tmr_voter #(.WIDTH(WIDTH)) u_voter (
         .copy0 (dom_copy[0]),
         .copy1 (dom_copy[1]),
         .copy2 (dom_copy[2]),
         .voted (dom_vote[k])
      );

      tmr_cell #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_cell (
         .clk     (dom_clk[k]),
         .rst     (rst),
         .load    (dom_en[k]),
         .din     (dom_din[k]),
         .refresh (dom_vote[k]),
         .state   (dom_copy[k])
      );
   end

   assign q_a      = dom_vote[0];
   assign q_b      = dom_vote[1];
   assign q_c      = dom_vote[2];
   assign mismatch = (dom_copy[0] ^ dom_copy[1]) | (dom_copy[1] ^ dom_copy[2]);

   // R6: the separate voters never disagree
   always_comb begin
      assert_voters_agree_R6: assert (q_a == q_b && q_b == q_c);
   end

   // R5: an all-idle edge leaves no disagreement behind
   assert_idle_scrubs_R5: assert property (@(posedge clk_a) disable iff (rst)
      (!en_a && !en_b && !en_c) |=> (mismatch == '0));

   // R3: a uniform write shows up on the outputs after the edge
   assert_uniform_write_R3: assert property (@(posedge clk_a) disable iff (rst)
      (en_a && en_b && en_c && d_a == d_b && d_b == d_c) |=> (q_a == $past(d_a)));

   // R4: a lone write is outvoted by the two idle copies
   assert_lone_write_masked_R4: assert property (@(posedge clk_a) disable iff (rst)
      (en_a && !en_b && !en_c) |=> (q_a == $past(q_a)));

   // R7: two matching writes win the vote
   assert_pair_write_wins_R7: assert property (@(posedge clk_a) disable iff (rst)
      (en_a && en_b && !en_c && d_a == d_b) |=> (q_b == $past(d_a)));
endmodule

// File: tb/tmr_refresh_reg_test.sv
module tmr_refresh_reg_test;
   localparam int unsigned W  = 8;
   localparam logic [W-1:0] RV = 8'hA5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en_a = 1'b0, en_b = 1'b0, en_c = 1'b0;
   logic [W-1:0] d_a = '0, d_b = '0, d_c = '0;
   logic [W-1:0] q_a, q_b, q_c, mismatch;

   int tests = 0;
   int fails = 0;
   logic [W-1:0] m [3];
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_refresh_reg #(.WIDTH(W), .RESET_VAL(RV)) uut (
      .clk_a(clk), .clk_b(clk), .clk_c(clk), .rst(rst),
      .en_a(en_a), .en_b(en_b), .en_c(en_c),
      .d_a(d_a), .d_b(d_b), .d_c(d_c),
      .q_a(q_a), .q_b(q_b), .q_c(q_c), .mismatch(mismatch));

   function automatic logic [W-1:0] model_vote();
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) begin
         int ones = 0;
         for (int k = 0; k < 3; k++) ones += m[k][i];
         r[i] = (ones >= 2);
      end
      return r;
   endfunction

   function automatic logic [W-1:0] model_flags();
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = !(m[0][i] == m[1][i] && m[1][i] == m[2][i]);
      return r;
   endfunction

   // behavioural model of the three copies
   always @(posedge clk) begin
      logic [W-1:0] v;
      v = model_vote();
      if (rst) begin
         for (int k = 0; k < 3; k++) m[k] = RV;
      end else begin
         m[0] = en_a ? d_a : v;
         m[1] = en_b ? d_b : v;
         m[2] = en_c ? d_c : v;
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare_model();
      chk("R2 q_a vs model", q_a, model_vote());
      chk("R6 q_b equals vote", q_b, model_vote());
      chk("R6 q_c equals vote", q_c, model_vote());
      chk("R8 mismatch vs model", mismatch, model_flags());
   endtask

   task automatic step(input logic ea, input logic eb, input logic ec,
                       input logic [W-1:0] da, input logic [W-1:0] db, input logic [W-1:0] dc);
      en_a = ea; en_b = eb; en_c = ec;
      d_a = da; d_b = db; d_c = dc;
      @(posedge clk);
      @(negedge clk);
      compare_model();
   endtask

   initial begin
      #1600000;
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 reset value", q_a, RV);
      chk("R1 reset mismatch", mismatch, '0);
      rst = 1'b0;

      step(1, 1, 1, 8'h3C, 8'h3C, 8'h3C);
      chk("R3 uniform write", q_c, 8'h3C);

      step(1, 0, 0, 8'h33, 8'h00, 8'h00);
      chk("R4 lone write masked", q_a, 8'h3C);
      chk("R4 lone write flags", mismatch, 8'h0F);

      step(0, 0, 0, 8'h00, 8'h00, 8'h00);
      chk("R5 idle repair flags", mismatch, 8'h00);
      chk("R5 idle repair value", q_b, 8'h3C);

      step(0, 0, 1, 8'h00, 8'h00, 8'hFF);
      chk("R4 lone write on domain 2", q_a, 8'h3C);
      chk("R4 lone write flags domain 2", mismatch, 8'hC3);
      step(0, 0, 0, 8'h00, 8'h00, 8'h00);
      chk("R5 repair domain 2", mismatch, 8'h00);

      step(1, 1, 0, 8'h81, 8'h81, 8'h00);
      chk("R7 double fault wins", q_a, 8'h81);
      chk("R7 double fault flags", mismatch, 8'hBD);
      step(0, 0, 0, 8'h00, 8'h00, 8'h00);
      chk("R7 third copy overwritten", mismatch, 8'h00);
      chk("R7 value persists", q_c, 8'h81);

      step(1, 1, 1, 8'hF0, 8'hCC, 8'hAA);
      chk("R9 bitwise majority", q_a, 8'hE8);
      chk("R8 partial disagreement", mismatch, 8'h7E);
      step(0, 0, 0, 8'h00, 8'h00, 8'h00);
      chk("R5 after three-way split", mismatch, 8'h00);

      for (int n = 0; n < 400; n++) begin
         logic [W-1:0] a, b, c;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = lfsr[7:0]; b = lfsr[15:8]; c = lfsr[11:4];
         if (n == 200) begin
            rst = 1'b1;
            step(1, 1, 1, a, b, c);
            chk("R1 reset overrides load", q_a, RV);
            rst = 1'b0;
         end else begin
            step(lfsr[0], lfsr[5], lfsr[9], a, b, c);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule